// File: doc/BRIEF.md
# Bus Sizing Data Conversion Controller

This controller sits on the system board between a processor with a 16-bit data bus and a system bus that may hold 8-bit targets. When the processor starts a word transfer at an even address, the controller checks whether the addressed target claims 16-bit capability. Memory and I/O targets each claim on their own strobe. If no target claims, the controller splits the transfer into two byte cycles. The first cycle moves the even byte on the low lane. The second cycle moves the odd byte, with the bus A0 forced high and the byte routed across the lanes through a swap path. The processor is held in wait states until both halves are complete.

On reads, the controller latches the byte from each half and presents the assembled word to the processor in the same cycle that ready rises. Transfers that a target claims, and byte-only transfers, run as a single bus cycle with no conversion. In those cycles ready follows the end of that one cycle.

Top module: `bus_size_conv`

## Requirements
- R1: After reset, conv_o, swap_gate_o, next_cyc_o and ready_o are all low.
- R2: A word request (bhe_ni=0 and a0_i=0 at the start_i pulse) whose matching capable strobe is high (inactive) starts a conversion. conv_o is high from the second clock edge after the start_i pulse.
- R3: The capable strobe is chosen by transfer type. io16_ni is used when io_i=1 and mem16_ni when io_i=0, and the other strobe has no effect. Both strobes are sampled at the first clock edge after the start_i pulse.
- R4: A word request whose matching strobe is low (claimed) runs as one cycle. conv_o and swap_gate_o stay low, a0_o equals the latched A0, and bus_wd_o equals cpu_wd_i.
- R5: A byte-only request (bhe_ni=1, or a0_i=1) never converts, whatever the strobes are.
- R6: During the first converted byte cycle, a0_o=0, swap_gate_o=0 and bus_wd_o equals cpu_wd_i.
- R7: On the clock edge where bus_done_i ends the first byte cycle, the second cycle begins. next_cyc_o pulses for exactly one cycle. For the rest of the conversion, a0_o=1 and swap_gate_o=1. swap_dir_o equals the latched wr_i (1 = write, upper processor byte to lower bus lane; 0 = read). bus_wd_o[7:0] carries cpu_wd_i[15:8].
- R8: ready_o stays low throughout a conversion. It is a single-cycle pulse on the cycle after the clock edge that sees the final bus_done_i, whether the transfer was converted or not.
- R9: On a converted read, cpu_rd_o is {second-cycle bus_rd_i[7:0], first-cycle bus_rd_i[7:0]} while ready_o is high.
- R10: On a read that is not converted, cpu_rd_o equals the bus_rd_i word sampled with bus_done_i while ready_o is high.
- R11: start_i is ignored while a transfer is in progress. It does not change the sequence, the lane routing or swap_dir_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse marking a new processor transfer |
| bhe_ni | input | 1 | Latched bus-high-enable, active low |
| a0_i | input | 1 | Address bit 0 of the processor transfer |
| io_i | input | 1 | Transfer type: 1 = I/O, 0 = memory |
| wr_i | input | 1 | Direction: 1 = write, 0 = read |
| mem16_ni | input | 1 | Memory target claims 16 bits, active low, idles high |
| io16_ni | input | 1 | I/O target claims 16 bits, active low, idles high |
| bus_done_i | input | 1 | End of the current system-bus cycle |
| bus_rd_i | input | 16 | Read data seen on the system bus |
| cpu_wd_i | input | 16 | Write data from the processor |
| conv_o | output | 1 | Conversion in progress |
| swap_gate_o | output | 1 | Enables the lane-swap transceiver |
| swap_dir_o | output | 1 | Swap direction: 1 = write, 0 = read |
| a0_o | output | 1 | A0 driven to the system bus |
| next_cyc_o | output | 1 | Pulse starting the second byte cycle |
| ready_o | output | 1 | Transfer complete, to the processor |
| cpu_rd_o | output | 16 | Assembled read data to the processor |
| bus_wd_o | output | 16 | Write data driven to the system bus |

## Verification
Word requests are tried with all four combinations of the two capable strobes, for both memory and I/O. This shows whether the right strobe is used and whether the other is ignored. Byte-only requests, with either bhe_ni high or a0_i high, run under all strobe values to show that they never convert. Reads and writes with random data and random bus wait lengths distinguish the lane routing of each half and the order in which the bytes are assembled. A start pulse injected in the middle of a conversion shows whether a busy controller ignores it.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_PASS,
    ST_FIRST,
    ST_RESTART,
    ST_SECOND,
    ST_DONE
  } bsc_state_e;
endpackage

// File: rtl/bsc_fsm.sv
module bsc_fsm
  import bsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bhe_ni,
  input  logic       a0_i,
  input  logic       io_i,
  input  logic       wr_i,
  input  logic       mem16_ni,
  input  logic       io16_ni,
  input  logic       bus_done_i,
  output bsc_state_e state_o,
  output logic       a0_q_o,
  output logic       wr_q_o
);
  bsc_state_e state_q, state_d;
  logic bhe_nq, a0_q, io_q, wr_q;
  logic word_req, claimed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bhe_nq <= 1'b1;
      a0_q   <= 1'b0;
      io_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else if (start_i && state_q == ST_IDLE) begin
      bhe_nq <= bhe_ni;
      a0_q   <= a0_i;
      io_q   <= io_i;
      wr_q   <= wr_i;
    end
  end

  assign word_req = !bhe_nq && !a0_q;
  // strobes are sampled only in ST_CHK
  assign claimed  = io_q ? !io16_ni : !mem16_ni;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CHK;
      ST_CHK:     state_d = (word_req && !claimed) ? ST_FIRST : ST_PASS;
      ST_PASS:    if (bus_done_i) state_d = ST_DONE;
      ST_FIRST:   if (bus_done_i) state_d = ST_RESTART;
      ST_RESTART: state_d = bus_done_i ? ST_DONE : ST_SECOND;
      ST_SECOND:  if (bus_done_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign a0_q_o  = a0_q;
  assign wr_q_o  = wr_q;

  // R5
  byte_no_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHK && (bhe_nq || a0_q)) |=> state_q == ST_PASS);

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> ($stable(wr_q) && $stable(a0_q)));
endmodule

// File: rtl/bsc_lanes.sv
module bsc_lanes
  import bsc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  bsc_state_e          state_i,
  input  logic                bus_done_i,
  input  logic                swap_i,
  input  logic [2*LANE_W-1:0] bus_rd_i,
  input  logic [2*LANE_W-1:0] cpu_wd_i,
  output logic [2*LANE_W-1:0] cpu_rd_o,
  output logic [2*LANE_W-1:0] bus_wd_o
);
  localparam int BUS_W = 2 * LANE_W;
  localparam int NLANE = 2;

  logic [BUS_W-1:0] rd_q;

  // write routing per lane: the low lane takes the upper byte while swapping
  for (genvar g = 0; g < NLANE; g++) begin : g_wlane
    if (g == 0) begin : g_low
      assign bus_wd_o[LANE_W-1:0] = swap_i ? cpu_wd_i[BUS_W-1:LANE_W]
                                           : cpu_wd_i[LANE_W-1:0];
    end else begin : g_high
      assign bus_wd_o[g*LANE_W +: LANE_W] = cpu_wd_i[g*LANE_W +: LANE_W];
    end
  end

  // read assembly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (bus_done_i) begin
      unique case (state_i)
        ST_PASS:              rd_q <= bus_rd_i;
        ST_FIRST:             rd_q[LANE_W-1:0] <= bus_rd_i[LANE_W-1:0];
        ST_RESTART, ST_SECOND: rd_q[BUS_W-1:LANE_W] <= bus_rd_i[LANE_W-1:0];
        default: ;
      endcase
    end
  end

  assign cpu_rd_o = rd_q;

  // R7
  swap_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |-> bus_wd_o[LANE_W-1:0] == cpu_wd_i[BUS_W-1:LANE_W]);
endmodule

// File: rtl/bus_size_conv.sv
module bus_size_conv
  import bsc_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bhe_ni,
  input  logic             a0_i,
  input  logic             io_i,
  input  logic             wr_i,
  input  logic             mem16_ni,
  input  logic             io16_ni,
  input  logic             bus_done_i,
  input  logic [BUS_W-1:0] bus_rd_i,
  input  logic [BUS_W-1:0] cpu_wd_i,
  output logic             conv_o,
  output logic             swap_gate_o,
  output logic             swap_dir_o,
  output logic             a0_o,
  output logic             next_cyc_o,
  output logic             ready_o,
  output logic [BUS_W-1:0] cpu_rd_o,
  output logic [BUS_W-1:0] bus_wd_o
);
  bsc_state_e state;
  logic a0_q, wr_q, odd_half;

  bsc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bhe_ni     (bhe_ni),
    .a0_i       (a0_i),
    .io_i       (io_i),
    .wr_i       (wr_i),
    .mem16_ni   (mem16_ni),
    .io16_ni    (io16_ni),
    .bus_done_i (bus_done_i),
    .state_o    (state),
    .a0_q_o     (a0_q),
    .wr_q_o     (wr_q)
  );

  assign odd_half    = (state == ST_RESTART) || (state == ST_SECOND);
  assign conv_o      = (state == ST_FIRST) || odd_half;
  assign swap_gate_o = odd_half;
  assign swap_dir_o  = wr_q;
  assign next_cyc_o  = (state == ST_RESTART);
  assign ready_o     = (state == ST_DONE);

  always_comb begin
    if (state == ST_FIRST) a0_o = 1'b0;
    else if (odd_half)     a0_o = 1'b1;
    else                   a0_o = a0_q;
  end

  bsc_lanes #(.LANE_W(LANE_W)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .bus_done_i (bus_done_i),
    .swap_i     (odd_half),
    .bus_rd_i   (bus_rd_i),
    .cpu_wd_i   (cpu_wd_i),
    .cpu_rd_o   (cpu_rd_o),
    .bus_wd_o   (bus_wd_o)
  );

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R8
  conv_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !ready_o);

  // R7
  swap_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_gate_o |-> (a0_o && conv_o));

  // R6
  first_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && !swap_gate_o) |-> !a0_o);

  // R7
  next_cyc_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_cyc_o |=> !next_cyc_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(conv_o || swap_gate_o || next_cyc_o || ready_o));
endmodule

// File: tb/tb_bus_size_conv.sv
module tb_bus_size_conv;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, bhe_ni = 1'b1, a0_i = 1'b0, io_i = 1'b0, wr_i = 1'b0;
  logic        mem16_ni = 1'b1, io16_ni = 1'b1, bus_done_i = 1'b0;
  logic [15:0] bus_rd_i = '0, cpu_wd_i = '0;
  logic        conv_o, swap_gate_o, swap_dir_o, a0_o, next_cyc_o, ready_o;
  logic [15:0] cpu_rd_o, bus_wd_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  bus_size_conv dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_conv(input bit bhe_n, input bit a0, input bit io,
                                  input bit m16n, input bit i16n);
    bit claim;
    claim = io ? !i16n : !m16n;
    return !bhe_n && !a0 && !claim;
  endfunction

  task automatic xfer(input bit bhe_n, input bit a0, input bit io, input bit wr,
                      input bit m16n, input bit i16n, input logic [15:0] wd,
                      input logic [7:0] b_lo, input logic [7:0] b_hi,
                      input int w1, input int w2, input bit poke);
    bit cv;
    cv = exp_conv(bhe_n, a0, io, m16n, i16n);
    @(negedge clk_i);
    start_i = 1; bhe_ni = bhe_n; a0_i = a0; io_i = io; wr_i = wr;
    mem16_ni = m16n; io16_ni = i16n; cpu_wd_i = wd;
    @(negedge clk_i);
    start_i = 0;
    @(negedge clk_i);
    chk(conv_o == cv, cv ? "R2" : (!bhe_n && !a0 ? "R4" : "R5"), conv_o, cv);
    chk(ready_o == 0, "R8", ready_o, 0);
    if (cv) begin
      chk(a0_o == 0 && swap_gate_o == 0, "R6", {a0_o, swap_gate_o}, 0);
      chk(bus_wd_o == wd, "R6", bus_wd_o, wd);
      for (int i = 0; i < w1; i++) begin
        if (poke && i == 0) begin
          start_i = 1; bhe_ni = 1; a0_i = 1; wr_i = !wr;
        end
        @(negedge clk_i);
        start_i = 0;
        chk(ready_o == 0 && conv_o == 1 && a0_o == 0, "R11", {ready_o, conv_o, a0_o}, 3'b010);
      end
      bus_done_i = 1; bus_rd_i = {~b_hi, b_lo};
      @(negedge clk_i);
      bus_done_i = 0;
      chk(next_cyc_o == 1, "R7", next_cyc_o, 1);
      chk(a0_o == 1 && swap_gate_o == 1, "R7", {a0_o, swap_gate_o}, 2'b11);
      chk(swap_dir_o == wr, "R7", swap_dir_o, wr);
      chk(bus_wd_o[7:0] == wd[15:8], "R7", bus_wd_o[7:0], wd[15:8]);
      chk(ready_o == 0, "R8", ready_o, 0);
      @(negedge clk_i);
      chk(next_cyc_o == 0 && swap_gate_o == 1 && a0_o == 1, "R7",
          {next_cyc_o, swap_gate_o, a0_o}, 3'b011);
      for (int i = 0; i < w2; i++) begin
        @(negedge clk_i);
        chk(ready_o == 0 && conv_o == 1, "R8", {ready_o, conv_o}, 2'b01);
      end
      bus_done_i = 1; bus_rd_i = {~b_lo, b_hi};
      @(negedge clk_i);
      bus_done_i = 0;
      chk(ready_o == 1 && conv_o == 0, "R8", {ready_o, conv_o}, 2'b10);
      if (!wr) chk(cpu_rd_o == {b_hi, b_lo}, "R9", cpu_rd_o, {b_hi, b_lo});
    end else begin
      chk(a0_o == a0 && swap_gate_o == 0, "R4", {a0_o, swap_gate_o}, {a0, 1'b0});
      chk(bus_wd_o == wd, "R4", bus_wd_o, wd);
      for (int i = 0; i < w1; i++) begin
        @(negedge clk_i);
        chk(ready_o == 0 && conv_o == 0 && next_cyc_o == 0, "R5",
            {ready_o, conv_o, next_cyc_o}, 0);
      end
      bus_done_i = 1; bus_rd_i = {b_hi, b_lo};
      @(negedge clk_i);
      bus_done_i = 0;
      chk(ready_o == 1, "R8", ready_o, 1);
      if (!wr) chk(cpu_rd_o == {b_hi, b_lo}, "R10", cpu_rd_o, {b_hi, b_lo});
    end
    @(negedge clk_i);
    chk(ready_o == 0 && conv_o == 0, "R8", {ready_o, conv_o}, 0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk_i);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk_i);
    // R1
    chk({conv_o, swap_gate_o, next_cyc_o, ready_o} == 0, "R1",
        {conv_o, swap_gate_o, next_cyc_o, ready_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk({conv_o, swap_gate_o, next_cyc_o, ready_o} == 0, "R1",
        {conv_o, swap_gate_o, next_cyc_o, ready_o}, 0);

    // R3: every strobe pair, memory and I/O, word read
    for (int t = 0; t < 8; t++)
      xfer(0, 0, t[2], 0, t[0], t[1], 16'h1234, 8'hA5, 8'h5A, 1, 1, 0);
    // R5: byte-only under all strobes
    for (int t = 0; t < 16; t++)
      xfer(!t[3] ? 1'b1 : t[0], t[3] ? 1'b1 : t[0], t[1], t[2], t[1], t[2],
           16'hBEEF, 8'h11, 8'h22, 0, 0, 0);
    // R6 R7 zero-wait converted write and read
    xfer(0, 0, 0, 1, 1, 1, 16'hC3A9, 8'h00, 8'hFF, 0, 0, 0);
    xfer(0, 0, 1, 0, 0, 1, 16'h0000, 8'hFF, 8'h00, 0, 0, 0);
    // R11 start pulse during conversion
    xfer(0, 0, 0, 1, 1, 1, 16'h7E81, 8'h3C, 8'hC3, 3, 2, 1);
    xfer(0, 0, 0, 0, 1, 1, 16'h7E81, 8'h3C, 8'hC3, 2, 1, 1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      xfer(r[0] & r[1], r[2] & r[3], r[4], r[5], r[6], r[7], r[23:8],
           r[31:24], r[15:8] ^ r[31:24], int'(r[25:24]), int'(r[27:26]), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule